// File: doc/BRIEF.md
# Motion Compensation Command Queue

This block sits between a register write port and a macroblock prediction engine. Software writes parameter words one after another to one command port. The block groups those words into commands and keeps up to four finished commands waiting. It passes them one at a time to the engine. Each command is run as three engine rounds, one each for the luma plane and the two chroma planes. Every round uses a one-cycle start pulse and a done pulse returned by the engine.

A one-word end command does not go to the engine. When it reaches the front of the queue, all work ahead of it is finished, so it raises a sticky end status and a level interrupt. Software may poll the status or take the interrupt. A header word that arrives while the queue is full is refused, and a sticky overflow flag records the loss. The remaining words of the refused command are then dropped, so the word stream keeps its alignment. Clearing the enable input drops everything that is waiting or half assembled.

Top module: `mc_cmd_queue`

## Requirements
- R1: The first word of a command is its header. Bits [3:0] give the word count: values 1..8 are used as given, and 0 or any value above 8 means 8. Bit 15 marks an end command, which is always one word long. Bits [5:4] select the prediction mode (0 intra, 1 forward, 2 backward, 3 bidirectional), which is presented on eng_mode.
- R2: A command is handed over once its last word has been received. eng_words carries word i in bits [16i+15:16i], and words beyond the count read as zero. eng_len gives the count. When the queue and engine are idle, eng_start is high in the second cycle after the clock edge that samples the last word.
- R3: At most four complete commands wait in the queue, not counting the one the engine is running. q_level shows the number waiting, and q_full is high when four are waiting.
- R4: A header word written while q_full is high is refused and sets the sticky ovf_sts. The remaining words of that command, as given by its header, are discarded. The word after them starts a new command.
- R5: Each command runs as three rounds, with eng_plane 0 (Y), then 1 (U), then 2 (V). eng_start is a one-cycle pulse. The next round, or the next queued command, starts in the cycle after eng_done is sampled.
- R6: An end command never starts the engine. It sets end_sts and irq only once every command ahead of it has finished all three rounds.
- R7: While en is high, sts_clr[0]=1 clears end_sts and irq, and sts_clr[1]=1 clears ovf_sts. If a set and a clear fall in the same cycle, the set wins.
- R8: While en is low, writes and clears are ignored. Waiting commands and any partly assembled command are dropped. A round already started completes, but no further round is issued. end_sts and ovf_sts keep their values.
- R9: After reset, eng_start, q_level, q_full, end_sts, ovf_sts and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low flushes the queue |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 16 | Command parameter word |
| sts_clr | input | 2 | Write-1 clears: bit 0 end status, bit 1 overflow |
| eng_start | output | 1 | One-cycle start of an engine round |
| eng_plane | output | 2 | Plane of the round: 0 Y, 1 U, 2 V |
| eng_mode | output | 2 | Prediction mode from the header |
| eng_len | output | 4 | Word count of the running command |
| eng_words | output | 128 | Parameter words of the running command |
| eng_done | input | 1 | Engine round finished |
| q_level | output | 3 | Number of waiting commands |
| q_full | output | 1 | Four commands waiting |
| end_sts | output | 1 | Sticky end status |
| ovf_sts | output | 1 | Sticky overflow status |
| irq | output | 1 | Processing-end interrupt |

## Verification
The hardest case to reach from the ports is a refused header whose trailing words arrive after the queue has drained. Only that case shows whether the dropped words are really discarded or taken as new commands. The bench holds the engine's done response so the running command stalls, fills the queue to four, and writes a three-word header. It then releases the engine, lets the queue empty, and writes two words shaped like end commands. Neither of them may raise end_sts or start the engine. A second hard case is dropping the enable while a round is in flight and a command is half assembled. The bench checks that the round finishes without any follow-up round, and that the next command is assembled from a fresh header.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
  // header word field positions (decoded by the assembler and the issuer)
  localparam int HDR_CNT_LSB  = 0;
  localparam int HDR_CNT_W    = 4;
  localparam int HDR_MODE_LSB = 4;
  localparam int HDR_MODE_W   = 2;
  localparam int HDR_END_BIT  = 15;

  typedef enum logic [1:0] {
    PLANE_Y = 2'd0,
    PLANE_U = 2'd1,
    PLANE_V = 2'd2
  } plane_e;

  typedef enum logic [1:0] {
    ISS_IDLE  = 2'd0,
    ISS_START = 2'd1,
    ISS_WAIT  = 2'd2
  } iss_state_e;
endpackage

// File: rtl/mcq_assembler.sv
module mcq_assembler
  import mcq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 8,
  parameter int LEN_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        wr_en,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic                        q_full,
  output logic                        push,
  output logic                        push_end,
  output logic [LEN_W-1:0]            push_len,
  output logic [MAX_WORDS*WORD_W-1:0] push_words,
  output logic                        ovf_set
);
  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  logic [IDX_W-1:0]                   idx_q, idx_d;
  logic [LEN_W-1:0]                   rem_q, rem_d;
  logic [LEN_W-1:0]                   len_q, len_d;
  logic                               disc_q, disc_d;
  logic [MAX_WORDS-1:0][WORD_W-1:0]   buf_q, buf_d;
  logic [HDR_CNT_W-1:0]               hdr_cnt;
  logic                               hdr_end;
  logic [LEN_W-1:0]                   hdr_len;
  logic                               at_header;
  logic                               buf_we;

  assign hdr_cnt   = wr_data[HDR_CNT_LSB +: HDR_CNT_W];
  assign hdr_end   = wr_data[HDR_END_BIT];
  assign at_header = (rem_q == '0);
  assign buf_we    = en & wr_en;

  always_comb begin
    if (hdr_end)
      hdr_len = LEN_W'(1);
    else if (hdr_cnt == '0 || LEN_W'(hdr_cnt) > LEN_W'(MAX_WORDS))
      hdr_len = LEN_W'(MAX_WORDS);
    else
      hdr_len = LEN_W'(hdr_cnt);
  end

  always_comb begin
    idx_d   = idx_q;
    rem_d   = rem_q;
    len_d   = len_q;
    disc_d  = disc_q;
    buf_d   = buf_q;
    push    = 1'b0;
    ovf_set = 1'b0;
    if (!en) begin
      idx_d  = '0;
      rem_d  = '0;
      disc_d = 1'b0;
    end else if (wr_en) begin
      if (at_header) begin
        if (q_full) begin
          ovf_set = 1'b1;
          rem_d   = hdr_len - LEN_W'(1);
          disc_d  = (hdr_len != LEN_W'(1));
        end else begin
          buf_d    = '0;
          buf_d[0] = wr_data;
          len_d    = hdr_len;
          if (hdr_len == LEN_W'(1)) begin
            push = 1'b1;
          end else begin
            idx_d  = IDX_W'(1);
            rem_d  = hdr_len - LEN_W'(1);
            disc_d = 1'b0;
          end
        end
      end else begin
        rem_d = rem_q - LEN_W'(1);
        if (!disc_q) begin
          buf_d[idx_q] = wr_data;
          idx_d        = idx_q + 1'b1;
          if (rem_q == LEN_W'(1)) push = 1'b1;
        end
        if (rem_q == LEN_W'(1)) begin
          disc_d = 1'b0;
          idx_d  = '0;
        end
      end
    end
  end

  assign push_end   = at_header & hdr_end;
  assign push_len   = at_header ? hdr_len : len_q;
  assign push_words = buf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      rem_q  <= '0;
      disc_q <= 1'b0;
      len_q  <= '0;
      buf_q  <= '0;
    end else begin
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      disc_q <= disc_d;
      if (buf_we) begin
        len_q <= len_d;
        buf_q <= buf_d;
      end
    end
  end

  // R3: never hand a command to a full queue
  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !q_full);
  // R4: a discard phase always has words left to swallow
  assert_discard_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disc_q |-> (rem_q != '0));
  // R8: disabling drops any half-built command
  assert_flush_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rem_q == '0));
endmodule

// File: rtl/mcq_fifo.sv
module mcq_fifo #(
  parameter int ENT_W = 8,
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [ENT_W-1:0] push_data,
  input  logic             pop,
  output logic [ENT_W-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             push_ok, pop_ok;

  assign empty   = (level_q == '0);
  assign full    = (level_q == LVL_W'(DEPTH));
  assign level   = level_q;
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (push_ok)
        wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)
        rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      if (push_ok && !pop_ok)
        level_d = level_q + 1'b1;
      else if (pop_ok && !push_ok)
        level_d = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && !flush && wr_ptr_q == PTR_W'(s))
        mem[s] <= push_data;
    end
  end

  // R3: the waiting count never exceeds the depth
  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH));
  // R5: the issuer only takes from a non-empty queue
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/mcq_issuer.sv
module mcq_issuer
  import mcq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 8,
  parameter int LEN_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        q_empty,
  input  logic                        head_end,
  input  logic [LEN_W-1:0]            head_len,
  input  logic [MAX_WORDS*WORD_W-1:0] head_words,
  output logic                        pop,
  output logic                        end_set,
  output logic                        eng_start,
  output logic [1:0]                  eng_plane,
  output logic [HDR_MODE_W-1:0]       eng_mode,
  output logic [LEN_W-1:0]            eng_len,
  output logic [MAX_WORDS*WORD_W-1:0] eng_words,
  input  logic                        eng_done
);
  iss_state_e                  st_q, st_d;
  plane_e                      plane_q, plane_d;
  logic [LEN_W-1:0]            len_q;
  logic [MAX_WORDS*WORD_W-1:0] words_q;
  logic                        round_fin, cmd_fin, slot_free, load;

  assign round_fin = (st_q == ISS_WAIT) & eng_done;
  assign cmd_fin   = round_fin & ((plane_q == PLANE_V) | ~en);
  assign slot_free = (st_q == ISS_IDLE) | cmd_fin;
  assign pop       = slot_free & en & ~q_empty;
  assign end_set   = pop & head_end;
  assign load      = pop & ~head_end;

  always_comb begin
    st_d    = st_q;
    plane_d = plane_q;
    case (st_q)
      ISS_START: st_d = ISS_WAIT;
      ISS_WAIT: begin
        if (round_fin) begin
          if (cmd_fin) begin
            st_d = ISS_IDLE;
          end else begin
            st_d    = ISS_START;
            plane_d = plane_e'(plane_q + 2'd1);
          end
        end
      end
      default: st_d = ISS_IDLE;
    endcase
    if (load) begin
      st_d    = ISS_START;
      plane_d = PLANE_Y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ISS_IDLE;
      plane_q <= PLANE_Y;
      len_q   <= '0;
      words_q <= '0;
    end else begin
      st_q    <= st_d;
      plane_q <= plane_d;
      if (load) begin
        len_q   <= head_len;
        words_q <= head_words;
      end
    end
  end

  assign eng_start = (st_q == ISS_START);
  assign eng_plane = plane_q;
  assign eng_mode  = words_q[HDR_MODE_LSB +: HDR_MODE_W];
  assign eng_len   = len_q;
  assign eng_words = words_q;

  // R5: start is a single-cycle pulse
  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R5: chroma rounds follow a done in the previous cycle
  assert_round_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && plane_q != PLANE_Y) |-> $past(eng_done));
  // R6: an end command is retired only with no round outstanding
  assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_set |=> !eng_start);
endmodule

// File: rtl/mc_cmd_queue.sv
module mc_cmd_queue
  import mcq_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 8,
  parameter int DEPTH     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        wr_en,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [1:0]                  sts_clr,
  output logic                        eng_start,
  output logic [1:0]                  eng_plane,
  output logic [HDR_MODE_W-1:0]       eng_mode,
  output logic [$clog2(MAX_WORDS+1)-1:0] eng_len,
  output logic [MAX_WORDS*WORD_W-1:0] eng_words,
  input  logic                        eng_done,
  output logic [$clog2(DEPTH+1)-1:0]  q_level,
  output logic                        q_full,
  output logic                        end_sts,
  output logic                        ovf_sts,
  output logic                        irq
);
  localparam int LEN_W = $clog2(MAX_WORDS+1);
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam int WV_W  = MAX_WORDS * WORD_W;
  localparam int ENT_W = 1 + LEN_W + WV_W;

  logic             push, push_end, ovf_set, pop, end_set, q_empty;
  logic [LEN_W-1:0] push_len;
  logic [WV_W-1:0]  push_words;
  logic [ENT_W-1:0] push_ent, head_ent;
  logic             end_q, end_d, ovf_q, ovf_d;

  mcq_assembler #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .q_full(q_full), .push(push), .push_end(push_end), .push_len(push_len),
    .push_words(push_words), .ovf_set(ovf_set)
  );

  assign push_ent = {push_end, push_len, push_words};

  mcq_fifo #(.ENT_W(ENT_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(~en), .push(push), .push_data(push_ent),
    .pop(pop), .head(head_ent), .empty(q_empty), .full(q_full), .level(q_level)
  );

  mcq_issuer #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_iss (
    .clk(clk), .rst_n(rst_n), .en(en), .q_empty(q_empty),
    .head_end(head_ent[ENT_W-1]), .head_len(head_ent[WV_W +: LEN_W]),
    .head_words(head_ent[WV_W-1:0]), .pop(pop), .end_set(end_set),
    .eng_start(eng_start), .eng_plane(eng_plane), .eng_mode(eng_mode),
    .eng_len(eng_len), .eng_words(eng_words), .eng_done(eng_done)
  );

  always_comb begin
    end_d = end_set | (end_q & ~(en & sts_clr[0]));
    ovf_d = ovf_set | (ovf_q & ~(en & sts_clr[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      end_q <= end_d;
      ovf_q <= ovf_d;
    end
  end

  assign end_sts = end_q;
  assign ovf_sts = ovf_q;
  assign irq     = end_q;

  // R4: overflow stays set until an enabled clear
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sts && !(en && sts_clr[1])) |=> ovf_sts);
  // R8: a disabled block keeps its end status
  assert_end_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_sts && !en) |=> end_sts);
  // R3: the full flag tracks the waiting count
  assert_full_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (q_level == LVL_W'(DEPTH)));
endmodule

// File: tb/tb_mc_cmd_queue.sv
module tb_mc_cmd_queue;
  logic         clk = 1'b0;
  logic         rst_n, en, wr_en, eng_done;
  logic [15:0]  wr_data;
  logic [1:0]   sts_clr;
  logic         eng_start, q_full, end_sts, ovf_sts, irq;
  logic [1:0]   eng_plane, eng_mode;
  logic [3:0]   eng_len;
  logic [127:0] eng_words;
  logic [2:0]   q_level;

  mc_cmd_queue dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_data(wr_data),
    .sts_clr(sts_clr), .eng_start(eng_start), .eng_plane(eng_plane),
    .eng_mode(eng_mode), .eng_len(eng_len), .eng_words(eng_words),
    .eng_done(eng_done), .q_level(q_level), .q_full(q_full),
    .end_sts(end_sts), .ovf_sts(ovf_sts), .irq(irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0, log_n = 0, last_wr_cyc = 0;
  bit hold = 0, finished = 0;
  logic [1:0]   log_plane [128];
  logic [1:0]   log_mode  [128];
  logic [3:0]   log_len   [128];
  logic [127:0] log_vec   [128];
  int           log_cyc   [128];
  int           done_cyc  [128];

  // table: {header word, expected count, expected mode}
  localparam logic [31:0] VEC [5] = '{
    32'h0013_03_01, 32'h0008_08_00, 32'h0030_08_03,
    32'h002C_08_02, 32'h0021_01_02 };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_wr_cyc = cyc;
  endtask

  task automatic send_cmd(input logic [15:0] w0, input int n);
    wr(w0);
    for (int k = 1; k < n; k++) wr(16'h4000 | 16'(k));
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // engine model
  initial begin
    eng_done = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (rst_n && eng_start) begin
        log_plane[log_n] = eng_plane;
        log_mode[log_n]  = eng_mode;
        log_len[log_n]   = eng_len;
        log_vec[log_n]   = eng_words;
        log_cyc[log_n]   = cyc;
        log_n++;
        while (hold) @(negedge clk);
        repeat (2) @(negedge clk);
        eng_done = 1'b1;
        done_cyc[log_n-1] = cyc;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int base, ln;
    logic [15:0] hdr;
    rst_n = 1'b0; en = 1'b1; wr_en = 1'b0; wr_data = '0; sts_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 start", eng_start, 0);
    check("R9 level", q_level, 0);
    check("R9 full", q_full, 0);
    check("R9 end", end_sts, 0);
    check("R9 ovf", ovf_sts, 0);
    check("R9 irq", irq, 0);

    // table walk: R1 header decode, R2 word placement, R5 plane order
    for (int v = 0; v < 5; v++) begin
      hdr = VEC[v][31:16];
      ln  = int'(VEC[v][15:8]);
      base = log_n;
      send_cmd(hdr, ln);
      wait_log(base + 3);
      for (int p = 0; p < 3; p++) check("R5 plane order", log_plane[base+p], p);
      check("R1 count", log_len[base], ln);
      check("R1 mode", log_mode[base], VEC[v][1:0]);
      check("R2 word0", log_vec[base][15:0], hdr);
      check("R2 last word", log_vec[base][16*(ln-1) +: 16],
            (ln == 1) ? hdr : (16'h4000 | 16'(ln-1)));
      check("R2 word7", log_vec[base][127:112], (ln == 8) ? 16'h4007 : 16'h0);
      repeat (4) @(negedge clk);
    end

    // R2 latency, R5 round gap
    base = log_n;
    send_cmd(16'h0001, 1);
    wait_log(base + 2);
    check("R2 start latency", log_cyc[base], last_wr_cyc + 1);
    check("R5 next round gap", log_cyc[base+1], done_cyc[base] + 1);
    wait_log(base + 3);
    repeat (4) @(negedge clk);

    // R3 / R4 full queue, refusal, discard
    hold = 1;
    base = log_n;
    send_cmd(16'h0001, 1);
    wait_log(base + 1);
    for (int c = 0; c < 4; c++) send_cmd(16'h0001, 1);
    check("R3 level four", q_level, 4);
    check("R3 full flag", q_full, 1);
    wr(16'h0003);
    check("R4 ovf set", ovf_sts, 1);
    check("R4 level unchanged", q_level, 4);
    hold = 0;
    wait_log(base + 15);
    repeat (8) @(negedge clk);
    check("R3 drained", q_level, 0);
    base = log_n;
    wr(16'h8000);
    wr(16'h8000);
    repeat (6) @(negedge clk);
    check("R4 discarded words no end", end_sts, 0);
    check("R4 discarded words no start", log_n, base);
    send_cmd(16'h0011, 1);
    wait_log(base + 3);
    check("R4 fresh cmd mode", log_mode[base], 1);
    check("R4 fresh cmd len", log_len[base], 1);
    repeat (6) @(negedge clk);

    // R6 end command
    hold = 1;
    base = log_n;
    send_cmd(16'h0001, 1);
    wr(16'h8000);
    repeat (4) @(negedge clk);
    check("R6 end waits for work", end_sts, 0);
    hold = 0;
    wait_log(base + 3);
    repeat (6) @(negedge clk);
    check("R6 end status", end_sts, 1);
    check("R6 irq", irq, 1);
    check("R6 no engine start", log_n, base + 3);

    // R8 enable low
    hold = 1;
    base = log_n;
    send_cmd(16'h0001, 1);
    wait_log(base + 1);
    send_cmd(16'h0001, 1);
    send_cmd(16'h0001, 1);
    check("R8 queued before flush", q_level, 2);
    wr(16'h0013);
    en = 1'b0;
    @(negedge clk);
    check("R8 flushed", q_level, 0);
    wr(16'h0001);
    sts_clr = 2'b11;
    @(negedge clk);
    sts_clr = 2'b00;
    check("R8 write ignored", q_level, 0);
    check("R8 ovf kept", ovf_sts, 1);
    check("R8 end kept", end_sts, 1);
    hold = 0;
    repeat (10) @(negedge clk);
    check("R8 no further rounds", log_n, base + 1);
    en = 1'b1;
    @(negedge clk);
    send_cmd(16'h0022, 2);
    wait_log(base + 4);
    check("R8 fresh len", log_len[base+1], 2);
    check("R8 fresh mode", log_mode[base+1], 2);
    check("R8 fresh word0", log_vec[base+1][15:0], 16'h0022);
    repeat (6) @(negedge clk);

    // R7 clears
    sts_clr = 2'b01;
    @(negedge clk);
    sts_clr = 2'b00;
    check("R7 end cleared", end_sts, 0);
    check("R7 irq cleared", irq, 0);
    check("R7 ovf untouched", ovf_sts, 1);
    sts_clr = 2'b10;
    @(negedge clk);
    sts_clr = 2'b00;
    check("R7 ovf cleared", ovf_sts, 0);

    finish_run();
  end
endmodule